// File: doc/BRIEF.md
# Dual-Clock FIFO with Cycle-Exact Status Flags

This block buffers data words between two unrelated clock domains. A producer pushes words on the write clock and a consumer pops them on the read clock. Each side sees its own set of status outputs: a full/empty pair, a one-entry warning, a programmable level mark, a per-operation acknowledge or valid pulse, an error pulse for a request that cannot be served, and an occupancy count. The two pointers cross domains as Gray code through a synchronizer chain whose depth, N, is a parameter.

Every status output has a fixed update latency. For an operation on its own port, latency is zero or one cycle. For an operation on the far port, latency is a fixed number of local cycles after the far edge, with one extra local cycle allowed for clock phase. The block reaches these latencies by adding register stages to the synchronized pointer, so each flag reads a pointer copy of a known age. The data words are held in a plain register array.

Top module: `xcf_fifo`

## Requirements
- R1: A write request while `wr_full` is low is accepted and gives a one-cycle `wr_ack` pulse after that wr_clk edge. Accepted words come out of `rd_data` in the order they were written.
- R2: `wr_full` (occupancy equals 2^ADDR_W) and `wr_near_full` (occupancy of at least 2^ADDR_W−1) show the effect of a write after the same wr_clk edge that takes it.
- R3: A write request while `wr_full` is high gives a one-cycle `wr_overflow` pulse and no `wr_ack`. The word is dropped and the occupancy does not change.
- R4: `wr_level` and `wr_above_mark` (occupancy of at least FULL_MARK) show the effect of a write one wr_clk edge later than the immediate flags.
- R5: An accepted read presents its word on `rd_data` with `rd_valid` high after the read edge. `rd_empty` (occupancy 0) and `rd_near_empty` (occupancy of at most 1) update after that same edge.
- R6: A read request while `rd_empty` is high gives a one-cycle `rd_underflow` pulse and no `rd_valid`. Nothing is popped.
- R7: `rd_level` and `rd_below_mark` (occupancy of at most EMPTY_MARK) show the effect of a read one rd_clk edge later than the immediate flags.
- R8: A read reaches `wr_full`, `wr_near_full` and `wr_level` on wr_clk edge N+2 after the read's rd_clk edge, and reaches `wr_above_mark` on edge N+3. In each case one extra wr_clk edge is allowed.
- R9: A write reaches `rd_level` on rd_clk edge N+2 after the write's wr_clk edge, `rd_below_mark` on edge N+3, and `rd_empty` and `rd_near_empty` on edge N+4. In each case one extra rd_clk edge is allowed.
- R10: While reset is low and after it is released, `rd_empty`, `rd_near_empty` and `rd_below_mark` are high. All other flags and pulses are low, and both levels are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free entry |
| wr_near_full | output | 1 | At most one free entry |
| wr_above_mark | output | 1 | Occupancy at or above FULL_MARK |
| wr_ack | output | 1 | Previous write was accepted |
| wr_overflow | output | 1 | Previous write was dropped |
| wr_level | output | ADDR_W+1 | Occupancy seen from the write side |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain synchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word from the last accepted read |
| rd_empty | output | 1 | No stored entry |
| rd_near_empty | output | 1 | At most one stored entry |
| rd_below_mark | output | 1 | Occupancy at or below EMPTY_MARK |
| rd_valid | output | 1 | rd_data holds a newly popped word |
| rd_underflow | output | 1 | Previous read found the FIFO empty |
| rd_level | output | ADDR_W+1 | Occupancy seen from the read side |

## Verification
The cross-domain latencies are the hardest behaviour to observe. A flag there moves only after a long synchronizer path, and it can be confused with the effect of a nearby operation on either port. The stimulus first lets both domains go idle, so every flag is stable. It then performs one write or read that takes the occupancy across exactly one threshold: empty, one entry, the low mark, the high mark, one free entry, or full. After that it counts the edges of the far clock until each flag moves, with the counting referenced to the time of the triggering edge. A randomized phase with fill-biased and drain-biased mixes then reaches overflow and underflow under traffic on both ports at once.

// File: rtl/xcf_pkg.sv
// Package: pointer code conversions shared by both clock domains.
// Assumes pointers no wider than 32 bits.
package xcf_pkg;

    // Binary to reflected Gray code.
    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary, MSB first.
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xcf_gray_sync.sv
// Module: multi-stage synchronizer for a Gray-coded pointer.
// Assumes the input changes at most one bit per source clock, which is true of Gray code.
// Latency: the output follows the input after STAGES destination edges.
module xcf_gray_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the sampled pointer through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/xcf_store.sv
// Module: register-array storage with a write port on wr_clk and a registered read port on rd_clk.
// Assumes the control logic never reads an entry whose write is still in flight.
module xcf_store #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store an accepted word.
    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the popped word at the read edge that pops it.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n)  rdata <= '0;
        else if (re)    rdata <= mem[raddr];
    end
endmodule

// File: rtl/xcf_wr_ctrl.sv
// Module: write-domain control. It owns the write pointer, the age-staged copies of the
//   read pointer, and all write-side flags.
// Latency plan (read pointer age in wr_clk edges after sync):
//   rptr_bin_q  N+1 : full / near-full / level registers land at N+2
//   rptr_old_q  N+2 : above-mark register lands at N+3
// Assumes rptr_gray_s comes from a Gray synchronizer in this domain.
module xcf_wr_ctrl
    import xcf_pkg::*;
#(
    parameter int AW        = 4,
    parameter int FULL_MARK = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW:0]   rptr_gray_s,
    output logic          wr_full,
    output logic          wr_near_full,
    output logic          wr_above_mark,
    output logic          wr_ack,
    output logic          wr_overflow,
    output logic [AW:0]   wr_level,
    output logic [AW:0]   wptr_gray,
    output logic [AW-1:0] waddr,
    output logic          accept
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] wptr_q, wptr_nxt, rptr_bin_q, rptr_old_q, occ_nxt;

    assign accept   = wr_en & ~wr_full;
    assign wptr_nxt = wptr_q + PW'(accept);
    assign occ_nxt  = wptr_nxt - rptr_bin_q;
    assign waddr    = wptr_q[AW-1:0];

    // Advance the write pointer and its Gray image together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q    <= '0;
            wptr_gray <= '0;
        end else begin
            wptr_q    <= wptr_nxt;
            wptr_gray <= PW'(bin_to_gray(32'(wptr_nxt)));
        end
    end

    // Decode the synchronized read pointer and keep one older copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_bin_q <= '0;
            rptr_old_q <= '0;
        end else begin
            rptr_bin_q <= PW'(gray_to_bin(32'(rptr_gray_s)));
            rptr_old_q <= rptr_bin_q;
        end
    end

    // Immediate flags: computed from the post-write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_full      <= 1'b0;
            wr_near_full <= 1'b0;
            wr_ack       <= 1'b0;
            wr_overflow  <= 1'b0;
        end else begin
            wr_full      <= (occ_nxt == PW'(DEPTH));
            wr_near_full <= (occ_nxt >= PW'(DEPTH - 1));
            wr_ack       <= accept;
            wr_overflow  <= wr_en & wr_full;
        end
    end

    // Lagging outputs: computed from the registered pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_level      <= '0;
            wr_above_mark <= 1'b0;
        end else begin
            wr_level      <= wptr_q - rptr_bin_q;
            wr_above_mark <= ((wptr_q - rptr_old_q) >= PW'(FULL_MARK));
        end
    end

    // An acknowledged write moved the pointer by exactly one.
    assert_ack_moves_ptr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> (wptr_q == $past(wptr_q) + PW'(1)));

    // A request while full leaves the pointer where it was.
    assert_full_blocks_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_full) |=> $stable(wptr_q));

    // Acknowledge and overflow never fire together.
    assert_ack_ovf_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ack && wr_overflow));

    // Full always implies near-full.
    assert_full_implies_near_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full |-> wr_near_full);

    // The pointer never runs more than DEPTH ahead of the read pointer it sees.
    assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr_q - rptr_bin_q) <= PW'(DEPTH));
endmodule

// File: rtl/xcf_rd_ctrl.sv
// Module: read-domain control. It owns the read pointer, the age-staged copies of the
//   write pointer, and all read-side flags.
// Latency plan (write pointer age in rd_clk edges after sync):
//   wptr_bin_q  N+1 : level register lands at N+2
//   wptr_d1_q   N+2 : below-mark register lands at N+3
//   wptr_d2_q   N+3 : empty / near-empty registers land at N+4
// An older write pointer is conservative, so the staging never exposes unwritten entries.
module xcf_rd_ctrl
    import xcf_pkg::*;
#(
    parameter int AW         = 4,
    parameter int EMPTY_MARK = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW:0]   wptr_gray_s,
    output logic          rd_empty,
    output logic          rd_near_empty,
    output logic          rd_below_mark,
    output logic          rd_valid,
    output logic          rd_underflow,
    output logic [AW:0]   rd_level,
    output logic [AW:0]   rptr_gray,
    output logic [AW-1:0] raddr,
    output logic          accept
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] rptr_q, rptr_nxt, wptr_bin_q, wptr_d1_q, wptr_d2_q, occ_nxt;

    assign accept   = rd_en & ~rd_empty;
    assign rptr_nxt = rptr_q + PW'(accept);
    assign occ_nxt  = wptr_d2_q - rptr_nxt;
    assign raddr    = rptr_q[AW-1:0];

    // Advance the read pointer and its Gray image together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q    <= '0;
            rptr_gray <= '0;
        end else begin
            rptr_q    <= rptr_nxt;
            rptr_gray <= PW'(bin_to_gray(32'(rptr_nxt)));
        end
    end

    // Decode the synchronized write pointer and age it by two more edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_bin_q <= '0;
            wptr_d1_q  <= '0;
            wptr_d2_q  <= '0;
        end else begin
            wptr_bin_q <= PW'(gray_to_bin(32'(wptr_gray_s)));
            wptr_d1_q  <= wptr_bin_q;
            wptr_d2_q  <= wptr_d1_q;
        end
    end

    // Immediate flags: computed from the post-read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_empty      <= 1'b1;
            rd_near_empty <= 1'b1;
            rd_valid      <= 1'b0;
            rd_underflow  <= 1'b0;
        end else begin
            rd_empty      <= (occ_nxt == '0);
            rd_near_empty <= (occ_nxt <= PW'(1));
            rd_valid      <= accept;
            rd_underflow  <= rd_en & rd_empty;
        end
    end

    // Lagging outputs: computed from the registered pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_level      <= '0;
            rd_below_mark <= 1'b1;
        end else begin
            rd_level      <= wptr_bin_q - rptr_q;
            rd_below_mark <= ((wptr_d1_q - rptr_q) <= PW'(EMPTY_MARK));
        end
    end

    // A valid word means the pointer moved by exactly one.
    assert_valid_moves_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rptr_q == $past(rptr_q) + PW'(1)));

    // A request while empty pops nothing.
    assert_empty_blocks_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_empty) |=> $stable(rptr_q));

    // Empty always implies near-empty.
    assert_empty_implies_near_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_empty |-> rd_near_empty);

    // The freshest write pointer seen is never more than DEPTH ahead.
    assert_rd_occ_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr_bin_q - rptr_q) <= PW'(DEPTH));
endmodule

// File: rtl/xcf_fifo.sv
// Module: dual-clock FIFO top. It joins storage, both domain controllers and the two
//   pointer synchronizers.
// Assumes ADDR_W >= 2, SYNC_STAGES >= 1, and marks inside 0..2^ADDR_W. Each reset is
//   synchronous to its own clock and both are held low together long enough for each domain.
module xcf_fifo #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int FULL_MARK   = 12,
    parameter int EMPTY_MARK  = 3
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic              wr_near_full,
    output logic              wr_above_mark,
    output logic              wr_ack,
    output logic              wr_overflow,
    output logic [ADDR_W:0]   wr_level,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              rd_near_empty,
    output logic              rd_below_mark,
    output logic              rd_valid,
    output logic              rd_underflow,
    output logic [ADDR_W:0]   rd_level
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wptr_gray, rptr_gray, wptr_gray_s, rptr_gray_s;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              wr_go, rd_go;

    xcf_wr_ctrl #(.AW(ADDR_W), .FULL_MARK(FULL_MARK)) wr_ctrl_i (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .rptr_gray_s(rptr_gray_s),
        .wr_full(wr_full), .wr_near_full(wr_near_full), .wr_above_mark(wr_above_mark),
        .wr_ack(wr_ack), .wr_overflow(wr_overflow), .wr_level(wr_level),
        .wptr_gray(wptr_gray), .waddr(waddr), .accept(wr_go)
    );

    xcf_rd_ctrl #(.AW(ADDR_W), .EMPTY_MARK(EMPTY_MARK)) rd_ctrl_i (
        .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wptr_gray_s(wptr_gray_s),
        .rd_empty(rd_empty), .rd_near_empty(rd_near_empty), .rd_below_mark(rd_below_mark),
        .rd_valid(rd_valid), .rd_underflow(rd_underflow), .rd_level(rd_level),
        .rptr_gray(rptr_gray), .raddr(raddr), .accept(rd_go)
    );

    xcf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) w2r_sync_i (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wptr_gray), .q(wptr_gray_s)
    );

    xcf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) r2w_sync_i (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rptr_gray), .q(rptr_gray_s)
    );

    xcf_store #(.DW(DATA_W), .AW(ADDR_W)) store_i (
        .wr_clk(wr_clk), .we(wr_go), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .re(rd_go), .raddr(raddr), .rdata(rd_data)
    );
endmodule

// File: tb/xcf_fifo_tb_top.sv
`timescale 1ns/1ps
// Bench: directed latency probes at each threshold, then seeded random two-port traffic.
module xcf_fifo_tb_top;
    localparam int DW = 8, AW = 4, N = 2, FM = 12, EM = 3;
    localparam int PW = AW + 1;

    logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0, wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0, rd_data;
    logic wr_full, wr_near_full, wr_above_mark, wr_ack, wr_overflow;
    logic rd_empty, rd_near_empty, rd_below_mark, rd_valid, rd_underflow;
    logic [PW-1:0] wr_level, rd_level;

    always #2.5 wr_clk = ~wr_clk;   // 200 MHz
    always #3.5 rd_clk = ~rd_clk;   // unrelated read clock

    xcf_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(N), .FULL_MARK(FM), .EMPTY_MARK(EM)) dut_i (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .wr_near_full(wr_near_full), .wr_above_mark(wr_above_mark),
        .wr_ack(wr_ack), .wr_overflow(wr_overflow), .wr_level(wr_level),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
        .rd_empty(rd_empty), .rd_near_empty(rd_near_empty), .rd_below_mark(rd_below_mark),
        .rd_valid(rd_valid), .rd_underflow(rd_underflow), .rd_level(rd_level)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [DW-1:0] mq[$];
    realtime t_w = 0, t_r = 0, wr_edge_t = 0, rd_edge_t = 0;
    logic [DW-1:0] seq = 8'hA0;

    always @(posedge wr_clk) wr_edge_t = $realtime;
    always @(posedge rd_clk) rd_edge_t = $realtime;

    function automatic bit in_rng(int v, int lo, int hi);
        return (v >= lo) && (v <= hi);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(string req, string what, int act, int lo, int hi);
        n_chk++;
        if (!in_rng(act, lo, hi)) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    // One write at a wr_clk edge. The model pushes the word if the FIFO was not full.
    task automatic wr_one();
        logic was_full;
        @(negedge wr_clk);
        was_full = wr_full; wr_en = 1; wr_data = seq;
        @(posedge wr_clk); t_w = $realtime; #0.5; wr_en = 0;
        chk("R1", "wr_ack", wr_ack, !was_full);
        chk("R3", "wr_overflow", wr_overflow, was_full);
        if (!was_full) mq.push_back(seq);
        seq++;
    endtask

    // One read at a rd_clk edge. The model pops and compares if the FIFO was not empty.
    task automatic rd_one();
        logic was_empty;
        logic [DW-1:0] e;
        @(negedge rd_clk);
        was_empty = rd_empty; rd_en = 1;
        @(posedge rd_clk); t_r = $realtime; #0.5; rd_en = 0;
        chk("R5", "rd_valid", rd_valid, !was_empty);
        chk("R6", "rd_underflow", rd_underflow, was_empty);
        if (!was_empty && mq.size() > 0) begin
            e = mq.pop_front();
            chk("R1", "rd_data order", rd_data, e);
        end
    endtask

    task automatic settle();
        repeat (30) @(posedge rd_clk);
        #0.5;
    endtask

    // Number rd_clk edges strictly after the write edge; report the first edge at which each flag moved.
    task automatic watch_rd(output int e_cnt, output int e_emp, output int e_aemp, output int e_pemp);
        logic [PW-1:0] p_cnt;
        logic p_e, p_a, p_p;
        int first;
        p_cnt = rd_level; p_e = rd_empty; p_a = rd_near_empty; p_p = rd_below_mark;
        e_cnt = 0; e_emp = 0; e_aemp = 0; e_pemp = 0;
        first = (rd_edge_t > t_w) ? 2 : 1;
        for (int i = first; i <= 16; i++) begin
            @(posedge rd_clk); #0.5;
            if (e_cnt == 0 && rd_level != p_cnt) e_cnt = i;
            if (e_emp == 0 && rd_empty != p_e) e_emp = i;
            if (e_aemp == 0 && rd_near_empty != p_a) e_aemp = i;
            if (e_pemp == 0 && rd_below_mark != p_p) e_pemp = i;
        end
    endtask

    // Number wr_clk edges strictly after the read edge; report the first edge at which each flag moved.
    task automatic watch_wr(output int e_cnt, output int e_full, output int e_afull, output int e_pfull);
        logic [PW-1:0] p_cnt;
        logic p_f, p_a, p_p;
        int first;
        p_cnt = wr_level; p_f = wr_full; p_a = wr_near_full; p_p = wr_above_mark;
        e_cnt = 0; e_full = 0; e_afull = 0; e_pfull = 0;
        first = (wr_edge_t > t_r) ? 2 : 1;
        for (int i = first; i <= 16; i++) begin
            @(posedge wr_clk); #0.5;
            if (e_cnt == 0 && wr_level != p_cnt) e_cnt = i;
            if (e_full == 0 && wr_full != p_f) e_full = i;
            if (e_afull == 0 && wr_near_full != p_a) e_afull = i;
            if (e_pfull == 0 && wr_above_mark != p_p) e_pfull = i;
        end
    endtask

    // Writer for the random phase; wp is the request probability in percent.
    task automatic rand_writer(int iters, int wp);
        for (int k = 0; k < iters; k++) begin
            logic f, en;
            logic [DW-1:0] d;
            @(negedge wr_clk);
            f = wr_full; en = (($urandom % 100) < wp); d = DW'($urandom);
            wr_en = en; wr_data = d;
            @(posedge wr_clk); #0.5;
            chk("R1", "rand wr_ack", wr_ack, en && !f);
            chk("R3", "rand wr_overflow", wr_overflow, en && f);
            if (en && !f) mq.push_back(d);
        end
        @(negedge wr_clk); wr_en = 0;
    endtask

    // Reader for the random phase; rp is the request probability in percent.
    task automatic rand_reader(int iters, int rp);
        for (int k = 0; k < iters; k++) begin
            logic e, en;
            logic [DW-1:0] x;
            @(negedge rd_clk);
            e = rd_empty; en = (($urandom % 100) < rp);
            rd_en = en;
            @(posedge rd_clk); #0.5;
            chk("R5", "rand rd_valid", rd_valid, en && !e);
            chk("R6", "rand rd_underflow", rd_underflow, en && e);
            if (en && !e && mq.size() > 0) begin
                x = mq.pop_front();
                chk("R1", "rand rd_data", rd_data, x);
            end
        end
        @(negedge rd_clk); rd_en = 0;
    endtask

    initial begin
        #900000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int a, b, c, d;
        void'($urandom(32'h5EED_0042));
        repeat (8) @(posedge rd_clk);
        // R10: flags while reset is held low
        #0.5;
        chk("R10", "rd_empty in reset", rd_empty, 1);
        chk("R10", "wr_full in reset", wr_full, 0);
        @(negedge wr_clk) wr_rst_n = 1;
        @(negedge rd_clk) rd_rst_n = 1;
        settle();
        // R10: state after release
        chk("R10", "rd_empty", rd_empty, 1);
        chk("R10", "rd_near_empty", rd_near_empty, 1);
        chk("R10", "rd_below_mark", rd_below_mark, 1);
        chk("R10", "wr_full", wr_full, 0);
        chk("R10", "wr_near_full", wr_near_full, 0);
        chk("R10", "wr_above_mark", wr_above_mark, 0);
        chk("R10", "pulses", {wr_ack, wr_overflow, rd_valid, rd_underflow}, 0);
        chk("R10", "wr_level", wr_level, 0);
        chk("R10", "rd_level", rd_level, 0);

        // R9: 0 -> 1 entry
        wr_one();
        chk("R2", "wr_full after 1st write", wr_full, 0);
        watch_rd(a, b, c, d);
        chk_rng("R9", "rd_level edge 0->1", a, N+2, N+3);
        chk_rng("R9", "rd_empty edge 0->1", b, N+4, N+5);
        chk("R9", "rd_near_empty steady 0->1", c, 0);
        chk("R9", "rd_below_mark steady 0->1", d, 0);
        // R9: 1 -> 2 entries clears near-empty
        wr_one();
        watch_rd(a, b, c, d);
        chk_rng("R9", "rd_near_empty edge 1->2", c, N+4, N+5);
        wr_one(); settle();
        // R9: 3 -> 4 entries leaves the low mark
        wr_one();
        watch_rd(a, b, c, d);
        chk_rng("R9", "rd_below_mark edge 3->4", d, N+3, N+4);
        chk_rng("R9", "rd_level edge 3->4", a, N+2, N+3);

        // R4: the level and high mark trail the write by one edge
        repeat (7) wr_one();
        settle();
        wr_one();
        chk("R4", "wr_level lag", wr_level, 11);
        chk("R4", "wr_above_mark lag", wr_above_mark, 0);
        @(posedge wr_clk); #0.5;
        chk("R4", "wr_level updated", wr_level, 12);
        chk("R4", "wr_above_mark updated", wr_above_mark, 1);
        // R2: near-full and full follow the write immediately
        wr_one(); wr_one();
        chk("R2", "wr_near_full at 14", wr_near_full, 0);
        wr_one();
        chk("R2", "wr_near_full at 15", wr_near_full, 1);
        chk("R2", "wr_full at 15", wr_full, 0);
        wr_one();
        chk("R2", "wr_full at 16", wr_full, 1);
        // R3: write while full
        wr_one();
        @(posedge wr_clk); #0.5;
        chk("R3", "wr_overflow single pulse", wr_overflow, 0);
        settle();
        chk("R3", "wr_level after drop", wr_level, 16);
        chk("R3", "rd_level after drop", rd_level, 16);

        // R8: 16 -> 15 clears full
        rd_one();
        chk("R7", "rd_level lag on read", rd_level, 16);
        watch_wr(a, b, c, d);
        chk_rng("R8", "wr_full edge 16->15", b, N+2, N+3);
        chk_rng("R8", "wr_level edge 16->15", a, N+2, N+3);
        chk("R8", "wr_near_full steady 16->15", c, 0);
        // R8: 15 -> 14 clears near-full
        rd_one();
        watch_wr(a, b, c, d);
        chk_rng("R8", "wr_near_full edge 15->14", c, N+2, N+3);
        rd_one(); rd_one(); settle();
        // R8: 12 -> 11 leaves the high mark
        rd_one();
        watch_wr(a, b, c, d);
        chk_rng("R8", "wr_above_mark edge 12->11", d, N+3, N+4);

        // R7: the low mark trails the read by one edge
        repeat (7) rd_one();
        settle();
        rd_one();
        chk("R7", "rd_below_mark lag", rd_below_mark, 0);
        chk("R7", "rd_level lag", rd_level, 4);
        @(posedge rd_clk); #0.5;
        chk("R7", "rd_below_mark updated", rd_below_mark, 1);
        chk("R7", "rd_level updated", rd_level, 3);
        rd_one(); rd_one();
        chk("R5", "rd_near_empty at 1", rd_near_empty, 1);
        chk("R5", "rd_empty at 1", rd_empty, 0);
        rd_one();
        chk("R5", "rd_empty at 0", rd_empty, 1);
        // R6: read while empty
        rd_one();
        @(posedge rd_clk); #0.5;
        chk("R6", "rd_underflow single pulse", rd_underflow, 0);
        settle();
        chk("R6", "rd_level after underflow", rd_level, 0);
        chk("R6", "wr_level after underflow", wr_level, 0);

        // Random traffic: fill-biased, then drain-biased
        fork
            rand_writer(1500, 70);
            rand_reader(1100, 35);
        join
        fork
            rand_writer(1100, 30);
            rand_reader(1500, 75);
        join
        settle();
        for (int g = 0; g < 40 && mq.size() > 0; g++) rd_one();
        settle();
        chk("R1", "model drained", mq.size(), 0);
        chk("R1", "rd_empty at end", rd_empty, 1);
        chk("R8", "wr_level at end", wr_level, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule